// File: doc/BRIEF.md
# Streaming Reed-Solomon Parity Encoder

This block turns a stream of byte symbols into systematic RS(255,223) codewords over GF(2^8). Each message symbol is forwarded to the output in the same cycle it is accepted, while a 32-stage division register accumulates the remainder of the message polynomial, scaled by x^32, divided by the generator polynomial. When the 223rd symbol has been accepted, the input is closed and the 32 remainder bytes follow on the same output stream. The register then holds all zeros, and the next block can start with no extra command.

The field is built on x^8+x^4+x^3+x^2+1 (0x11D) with alpha = 0x02. The generator polynomial has roots alpha^0 through alpha^31. Its coefficients are computed when the design is elaborated. Every product by a generator coefficient is a fixed XOR network with no lookup table. Both sides of the block use a valid/ready handshake. A symbol moves when valid and ready are both high at a rising clock edge.

Top module: `rs_stream_enc`

## Requirements
- R1: In the message phase, out_valid_o equals in_valid_i, out_data_o equals in_data_i, and in_ready_o equals out_ready_i. Accepted symbols appear on the output unchanged and in arrival order.
- R2: After 223 accepted message symbols, exactly 32 parity bytes are emitted, highest degree first. Together with the message they form a codeword whose value at each of alpha^0..alpha^31 is zero, where the first message byte is the highest-degree coefficient.
- R3: During the parity phase, in_ready_o is low and in_valid_i/in_data_i have no effect on the output stream.
- R4: During the parity phase, out_valid_o stays high. While out_ready_i is low, out_data_o holds its value and no parity byte is lost or repeated.
- R5: In the message phase, a cycle with out_ready_i low or in_valid_i low consumes nothing and does not advance the block.
- R6: After the 32nd parity byte is taken, the block returns to the message phase with a cleared remainder, so back-to-back blocks are encoded independently.
- R7: Asynchronous active-low reset rst_ni puts the block in the message phase at symbol 0 with a cleared remainder, discarding any partial block.
- R8: An all-zero message produces 32 zero parity bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Message symbol |
| in_valid_i | input | 1 | Message symbol valid |
| in_ready_o | output | 1 | Encoder accepts a symbol |
| out_data_o | output | 8 | Codeword symbol (message or parity) |
| out_valid_o | output | 1 | Codeword symbol valid |
| out_ready_i | input | 1 | Downstream accepts a symbol |

## Verification
The hardest case to reach is the handover from message to parity under backpressure. The stimulus has to stall downstream on the exact cycle the 223rd symbol is offered, then again partway through the parity burst, while upstream keeps offering junk that must not be taken. Blocks in the stimulus table mix periodic output stalls, input gaps and unbroken flow, and they run back to back, so each boundary is crossed under a different pattern. Parity is checked against a long division done in the bench, and also by evaluating the full codeword at all 32 roots.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [8:0] FIELD_POLY = 9'h11D;
  localparam int MAXP = 64;
  localparam int GEN_W = MAXP * SYM_W + SYM_W;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? FIELD_POLY[7:0] : 8'h00);
    end
    return p;
  endfunction

  // product of (x + alpha^i), i = 0..npar-1; byte j is the x^j coefficient
  function automatic logic [GEN_W-1:0] gen_poly(input int npar);
    logic [GEN_W-1:0] g;
    logic [7:0] root;
    logic [7:0] lo;
    g = '0;
    g[7:0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < npar; i++) begin
      for (int j = MAXP; j >= 0; j--) begin
        if (j > 0) lo = g[(j-1)*8 +: 8];
        else       lo = 8'h00;
        g[j*8 +: 8] = lo ^ gf_mul(root, g[j*8 +: 8]);
      end
      root = gf_mul(root, 8'h02);
    end
    return g;
  endfunction

  // input bits that feed output bit j of a multiply by coef
  function automatic logic [7:0] cmul_mask(input logic [7:0] coef, input int j);
    logic [7:0] m;
    logic [7:0] t;
    for (int k = 0; k < 8; k++) begin
      t = gf_mul(coef, 8'(1 << k));
      m[k] = t[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter logic [7:0] COEF = 8'h01
) (
  input  logic [7:0] a_i,
  output logic [7:0] p_o
);
  for (genvar j = 0; j < 8; j++) begin : g_bit
    localparam logic [7:0] MASK = cmul_mask(COEF, j);
    assign p_o[j] = ^(a_i & MASK);
  end
endmodule

// File: rtl/rs_lfsr.sv
module rs_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 32,
  parameter logic [GEN_W-1:0] GEN = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shift_i,
  input  logic       load_i,
  input  logic [7:0] sym_i,
  output logic [7:0] top_o,
  output logic       zero_o
);
  logic [7:0] r_q [NPAR];
  logic [7:0] prod [NPAR];
  logic [7:0] fb;

  // parity phase: zero feedback turns the divider into a plain shifter
  assign fb = load_i ? (sym_i ^ r_q[NPAR-1]) : 8'h00;

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    rs_gf_cmul #(.COEF(GEN[i*8 +: 8])) u_mul (.a_i(fb), .p_o(prod[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPAR; i++) r_q[i] <= '0;
    end else if (shift_i) begin
      r_q[0] <= prod[0];
      for (int i = 1; i < NPAR; i++) r_q[i] <= r_q[i-1] ^ prod[i];
    end
  end

  always_comb begin
    zero_o = 1'b1;
    for (int i = 0; i < NPAR; i++) if (r_q[i] != 8'h00) zero_o = 1'b0;
  end

  assign top_o = r_q[NPAR-1];
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl #(
  parameter int NMSG = 223,
  parameter int NPAR = 32,
  parameter int CW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  output logic          par_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o <= 1'b0;
      cnt_o <= '0;
    end else if (fire_i) begin
      if (!par_o) begin
        if (cnt_o == CW'(NMSG-1)) begin
          par_o <= 1'b1;
          cnt_o <= '0;
        end else cnt_o <= cnt_o + 1'b1;
      end else begin
        if (cnt_o == CW'(NPAR-1)) begin
          par_o <= 1'b0;
          cnt_o <= '0;
        end else cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_stream_enc.sv
module rs_stream_enc
  import rs_enc_pkg::*;
#(
  parameter int NMSG = 223,
  parameter int NPAR = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  input  logic       out_ready_i
);
  localparam int CMAX = (NMSG > NPAR) ? NMSG : NPAR;
  localparam int CW = $clog2(CMAX);
  localparam logic [GEN_W-1:0] GEN = gen_poly(NPAR);

  logic          par_q;
  logic [CW-1:0] cnt_q;
  logic          fire;
  logic [7:0]    lfsr_top;
  logic          lfsr_zero;

  assign in_ready_o  = !par_q && out_ready_i;
  assign out_valid_o = par_q || in_valid_i;
  assign out_data_o  = par_q ? lfsr_top : in_data_i;
  assign fire        = out_valid_o && out_ready_i;

  rs_ctrl #(.NMSG(NMSG), .NPAR(NPAR), .CW(CW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .par_o(par_q), .cnt_o(cnt_q)
  );

  rs_lfsr #(.NPAR(NPAR), .GEN(GEN)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(fire), .load_i(!par_q),
    .sym_i(in_data_i), .top_o(lfsr_top), .zero_o(lfsr_zero)
  );
endmodule

// File: rtl/rs_stream_enc_chk.sv
module rs_stream_enc_chk #(
  parameter int NMSG = 223,
  parameter int NPAR = 32,
  parameter int CW   = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [7:0]    out_data_o,
  input logic          par_phase,
  input logic [CW-1:0] cnt,
  input logic          state_zero
);
  AST_PAR_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_phase |-> !in_ready_o); // R3
  AST_PAR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_phase |-> out_valid_o); // R4
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_phase && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R4
  AST_ENTER_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_phase && cnt == CW'(NMSG-1) && in_valid_i && in_ready_o |=> par_phase); // R2
  AST_BLOCK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_phase && cnt == CW'(NPAR-1) && out_ready_i |=> !par_phase && cnt == '0 && state_zero); // R6
  AST_MSG_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_phase && !out_ready_i |-> !in_ready_o); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && out_ready_i) |=> $stable(cnt) && $stable(par_phase)); // R5
endmodule

bind rs_stream_enc rs_stream_enc_chk #(.NMSG(NMSG), .NPAR(NPAR), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .par_phase(par_q), .cnt(cnt_q), .state_zero(lfsr_zero)
);

// File: tb/sim_rs_stream_enc.sv
module sim_rs_stream_enc;
  localparam int NMSG = 223;
  localparam int NPAR = 32;
  localparam int NCW  = NMSG + NPAR;
  localparam int NVEC = 5;
  // {seed, step, mode}; mode 0 free flow, 1 output stalls, 2 input gaps + stalls
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'd0}, {8'h01, 8'h01, 8'd0}, {8'hFF, 8'h00, 8'd1},
    {8'h5A, 8'h3B, 8'd2}, {8'h80, 8'h07, 8'd1}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [7:0] out_data;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] cw [NCW];
  logic [7:0] g [NPAR+1];

  always #5 clk = ~clk;

  rs_stream_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = 0;
    for (int i = 0; i < 8; i++) if (b[i]) acc ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (acc[i]) acc ^= 16'h11D << (i - 8);
    return acc[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_gen();
    logic [7:0] r = 8'h01;
    for (int j = 0; j <= NPAR; j++) g[j] = 0;
    g[0] = 1;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j >= 1; j--) g[j] = g[j-1] ^ fmul(r, g[j]);
      g[0] = fmul(r, g[0]);
      r = fmul(r, 8'h02);
    end
  endtask

  task automatic run_block(input logic [7:0] seed, input logic [7:0] step, input int mode);
    logic [7:0] buf_q [NCW];
    int k = 0, p = 0, cyc = 0;
    int e1 = 0, e3 = 0, e4 = 0, e5 = 0, bad_par = 0, bad_syn = 0;
    bit held = 0;
    logic [7:0] held_d = 0, m, s, x;
    while (k < NMSG) begin
      @(negedge clk); cyc++;
      m = 8'(seed + step * k);
      in_valid  = !(mode == 2 && cyc % 5 == 0);
      out_ready = !(mode != 0 && cyc % 3 == 0);
      in_data   = m;
      #1;
      if (out_valid !== in_valid || (in_valid && out_data !== m)) e1++;
      if (in_ready !== out_ready) e1++;
      if (!out_ready && in_ready !== 1'b0) e5++;
      if (in_valid && out_ready) begin cw[k] = m; k++; end
    end
    while (p < NPAR) begin
      @(negedge clk); cyc++;
      in_valid  = 1;
      in_data   = 8'hA5;
      out_ready = !(mode != 0 && cyc % 3 == 0);
      #1;
      if (in_ready !== 1'b0) e3++;
      if (out_valid !== 1'b1) e4++;
      if (held && out_data !== held_d) e4++;
      if (out_ready) begin cw[NMSG + p] = out_data; p++; held = 0; end
      else begin held = 1; held_d = out_data; end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    #1;
    // R6: back in message phase
    check(out_valid === 1'b0 && in_ready === 1'b1, "R6 phase return", {out_valid, in_ready}, 2'b01);
    for (int i = 0; i < NCW; i++) buf_q[i] = (i < NMSG) ? cw[i] : 8'h00;
    for (int i = 0; i < NMSG; i++) begin
      x = buf_q[i];
      for (int j = 1; j <= NPAR; j++) buf_q[i+j] ^= fmul(x, g[NPAR-j]);
    end
    for (int i = 0; i < NPAR; i++) if (buf_q[NMSG+i] !== cw[NMSG+i]) bad_par++;
    x = 8'h01;
    for (int r = 0; r < NPAR; r++) begin
      s = 0;
      for (int i = 0; i < NCW; i++) s = fmul(s, x) ^ cw[i];
      if (s != 0) bad_syn++;
      x = fmul(x, 8'h02);
    end
    check(e1 == 0, "R1 passthrough", e1, 0);
    check(bad_par == 0, "R2 parity vs division", bad_par, 0);
    check(bad_syn == 0, "R2 codeword roots", bad_syn, 0);
    check(e3 == 0, "R3 input closed in parity", e3, 0);
    if (mode != 0) begin
      check(e4 == 0, "R4 parity stall hold", e4, 0);
      check(e5 == 0, "R5 message stall", e5, 0);
    end
    if (seed == 0 && step == 0) begin
      int nz = 0;
      for (int i = 0; i < NPAR; i++) if (cw[NMSG+i] != 0) nz++;
      check(nz == 0, "R8 zero parity", nz, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    build_gen();
    repeat (3) @(negedge clk);
    out_ready = 1;
    #1;
    // R7: reset state, message phase
    check(out_valid === 1'b0 && in_ready === 1'b1, "R7 reset state", {out_valid, in_ready}, 2'b01);
    @(negedge clk); rst_n = 1;
    for (int v = 0; v < NVEC; v++) run_block(VEC[v][23:16], VEC[v][15:8], int'(VEC[v][7:0]));
    // R7: partial block discarded by reset
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'(i * 13 + 1); out_ready = 1;
    end
    @(negedge clk); in_valid = 0; rst_n = 0;
    #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R7 mid-block reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk); rst_n = 1;
    run_block(8'h33, 8'h11, 1);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule